// File: doc/BRIEF.md
# Level-Prioritized Interrupt Arbiter

The block gathers interrupt requests from a parameterized set of peripheral sources. Each source has a pending flag inside the block. The flag is set by a one-cycle event strobe from that source and cleared by an explicit acknowledge strobe. Each source also has a small configuration word, written over a plain address/data/strobe port. The word holds an enable bit, a service-select bit and a 3-bit priority level.

A source competes only when it is pending, enabled and programmed to a level other than 7. The competitor with the numerically smallest level wins. Among equal levels, the lowest source number wins.

The registered result gives the CPU side the following:
- a valid flag;
- the winning level, source number and service-select bit;
- an accept signal.

Accept is high only when the winning level is strictly below the CPU's current mask level and the CPU's global interrupt enable is set.

The outputs are plain status pins with no handshake, so there is no back-pressure. The CPU side sees the state as long as it holds. It withdraws a request by pulsing that source's clear strobe. The winner and accept are recomputed every clock.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, irq_valid, irq_accept and irq_service_sel are 0, irq_level is 7 and irq_src is 0. Every source resets to not pending, with enable 0, service-select 0 and level 7.
- R2: A source competes only when its pending flag is 1, its enable bit is 1 and its level is not 7. Level 7 acts as a disable.
- R3: Among competing sources, the one with the numerically smallest level is presented on irq_level and irq_src.
- R4: When competing sources share the smallest level, the lowest source number wins.
- R5: irq_accept is 1 only when irq_valid is 1 and irq_level is strictly less than cpu_mask. A level equal to the mask is not accepted.
- R6: irq_accept is 0 whenever cpu_ie is 0.
- R7: irq_service_sel shows the winning source's service-select bit. A value of 0 denotes a normal interrupt.
- R8: A pending flag stays set across any number of cycles until a clear strobe for that source. The clear strobe drops it.
- R9: When an event strobe and a clear strobe hit the same source in the same cycle, the flag ends up set.
- R10: On a clock edge with cfg_wr_en high, the configuration of source cfg_wr_addr takes cfg_wr_data. Bit 4 is enable, bit 3 is service-select and bits 2:0 are the level. The other sources are unchanged.
- R11: With no competing source, irq_valid is 0, irq_level is 7, irq_src is 0, irq_service_sel is 0 and irq_accept is 0.
- R12: An event or configuration write taken at edge k shows on the outputs after edge k+1. A change of cpu_mask or cpu_ie sampled at edge k shows on irq_accept after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_event | input | N_SRC | One-cycle per-source request events |
| src_clear | input | N_SRC | One-cycle per-source acknowledge (clear) strobes |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | SRC_W | Source number being configured |
| cfg_wr_data | input | 5 | {enable, service-select, level[2:0]} |
| cpu_mask | input | 3 | Current CPU mask level |
| cpu_ie | input | 1 | CPU global interrupt enable |
| irq_valid | output | 1 | A competing request exists |
| irq_level | output | 3 | Winning level, 7 when idle |
| irq_src | output | SRC_W | Winning source number, 0 when idle |
| irq_service_sel | output | 1 | Winning source's service-select bit |
| irq_accept | output | 1 | Winner may be taken by the CPU |

## Verification
Two functions can land on the same source in one cycle. A new event and an acknowledge can both hit the flag. A configuration write can also change a source's level while that source is pending and competing. The bench drives the event and clear strobes together on one source, then checks that the source still wins on the next result. It rewrites the level of a pending source and checks that the winner moves to the source that R3 and R4 predict. Each expected outcome comes from a shadow model in the bench that keeps only the requirement-level state.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 3;
  localparam logic [LVL_W-1:0] LVL_OFF = 3'd7;

  // field order matches cfg_wr_data: [4]=enable, [3]=service select, [2:0]=level
  typedef struct packed {
    logic             en;
    logic             ssel;
    logic [LVL_W-1:0] lvl;
  } src_cfg_t;

  localparam int CFG_W = $bits(src_cfg_t);
endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 16,
  parameter int SRC_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-1:0]       src_event,
  input  logic [N_SRC-1:0]       src_clear,
  input  logic                   wr_en,
  input  logic [SRC_W-1:0]       wr_addr,
  input  src_cfg_t               wr_data,
  output logic [N_SRC-1:0]       pend_o,
  output src_cfg_t [N_SRC-1:0]   cfg_o
);
  localparam src_cfg_t CFG_RST = '{en: 1'b0, ssel: 1'b0, lvl: LVL_OFF};

  logic [N_SRC-1:0]     pend_q;
  src_cfg_t [N_SRC-1:0] cfg_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    localparam logic [SRC_W-1:0] MY_ADDR = SRC_W'(i);

    // event has priority over clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pend_q[i] <= 1'b0;
      else if (src_event[i]) pend_q[i] <= 1'b1;
      else if (src_clear[i]) pend_q[i] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           cfg_q[i] <= CFG_RST;
      else if (wr_en && wr_addr == MY_ADDR) cfg_q[i] <= wr_data;
    end

    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_event[i] |=> pend_q[i]);
    // R8
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_clear[i] && !src_event[i]) |=> !pend_q[i]);
    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[i] && !src_clear[i]) |=> pend_q[i]);
  end

  assign pend_o = pend_q;
  assign cfg_o  = cfg_q;
endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 16,
  parameter int SRC_W = 4
) (
  input  logic [N_SRC-1:0]     elig,
  input  src_cfg_t [N_SRC-1:0] cfg,
  output logic                 win_valid,
  output logic [LVL_W-1:0]     win_lvl,
  output logic [SRC_W-1:0]     win_idx,
  output logic                 win_ssel
);
  localparam int LEAVES = 1 << $clog2(N_SRC);
  localparam int NODES  = 2 * LEAVES - 1;
  localparam int LEAF0  = LEAVES - 1;

  logic             nv [NODES];
  logic [LVL_W-1:0] nl [NODES];
  logic [SRC_W-1:0] ni [NODES];
  logic             ns [NODES];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < N_SRC) begin : g_real
      assign nv[LEAF0+j] = elig[j];
      assign nl[LEAF0+j] = cfg[j].lvl;
      assign ni[LEAF0+j] = SRC_W'(j);
      assign ns[LEAF0+j] = cfg[j].ssel;
    end else begin : g_pad
      assign nv[LEAF0+j] = 1'b0;
      assign nl[LEAF0+j] = LVL_OFF;
      assign ni[LEAF0+j] = '0;
      assign ns[LEAF0+j] = 1'b0;
    end
  end

  // left subtree holds lower source numbers, so a tie keeps the left side
  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    logic take_l;
    assign take_l = nv[2*k+1] && (!nv[2*k+2] || (nl[2*k+1] <= nl[2*k+2]));
    assign nv[k]  = nv[2*k+1] || nv[2*k+2];
    assign nl[k]  = take_l ? nl[2*k+1] : nl[2*k+2];
    assign ni[k]  = take_l ? ni[2*k+1] : ni[2*k+2];
    assign ns[k]  = take_l ? ns[2*k+1] : ns[2*k+2];
  end

  assign win_valid = nv[0];
  assign win_lvl   = nl[0];
  assign win_idx   = ni[0];
  assign win_ssel  = ns[0];
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 16,
  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SRC-1:0]   src_event,
  input  logic [N_SRC-1:0]   src_clear,
  input  logic               cfg_wr_en,
  input  logic [SRC_W-1:0]   cfg_wr_addr,
  input  logic [CFG_W-1:0]   cfg_wr_data,
  input  logic [LVL_W-1:0]   cpu_mask,
  input  logic               cpu_ie,
  output logic               irq_valid,
  output logic [LVL_W-1:0]   irq_level,
  output logic [SRC_W-1:0]   irq_src,
  output logic               irq_service_sel,
  output logic               irq_accept
);
  logic [N_SRC-1:0]     pend;
  src_cfg_t [N_SRC-1:0] cfg;
  logic [N_SRC-1:0]     elig;
  logic                 win_valid;
  logic [LVL_W-1:0]     win_lvl;
  logic [SRC_W-1:0]     win_idx;
  logic                 win_ssel;

  irq_req_bank #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_event(src_event),
    .src_clear(src_clear),
    .wr_en    (cfg_wr_en),
    .wr_addr  (cfg_wr_addr),
    .wr_data  (src_cfg_t'(cfg_wr_data)),
    .pend_o   (pend),
    .cfg_o    (cfg)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    assign elig[i] = pend[i] && cfg[i].en && (cfg[i].lvl != LVL_OFF);
  end

  irq_prio_tree #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_tree (
    .elig     (elig),
    .cfg      (cfg),
    .win_valid(win_valid),
    .win_lvl  (win_lvl),
    .win_idx  (win_idx),
    .win_ssel (win_ssel)
  );

  logic [N_SRC-1:0] elig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid       <= 1'b0;
      irq_level       <= LVL_OFF;
      irq_src         <= '0;
      irq_service_sel <= 1'b0;
      irq_accept      <= 1'b0;
      elig_q          <= '0;
    end else begin
      irq_valid       <= win_valid;
      irq_level       <= win_valid ? win_lvl : LVL_OFF;
      irq_src         <= win_valid ? win_idx : '0;
      irq_service_sel <= win_valid && win_ssel;
      irq_accept      <= win_valid && cpu_ie && (win_lvl < cpu_mask);
      elig_q          <= elig;
    end
  end

  // R11
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_level == LVL_OFF && irq_src == '0 && !irq_accept && !irq_service_sel));
  // R5 R6
  accept_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_accept == (irq_valid && $past(cpu_ie) && (irq_level < $past(cpu_mask))));
  // R2
  winner_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> elig_q[irq_src]);
  // R12
  valid_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid == $past(|elig));
endmodule

// File: tb/irq_level_arbiter_tb.sv
`timescale 1ns/1ps
module irq_level_arbiter_tb;
  localparam int N = 16;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_event = '0;
  logic [N-1:0]  src_clear = '0;
  logic          cfg_wr_en = 1'b0;
  logic [SW-1:0] cfg_wr_addr = '0;
  logic [4:0]    cfg_wr_data = '0;
  logic [2:0]    cpu_mask = 3'd7;
  logic          cpu_ie = 1'b1;
  logic          irq_valid;
  logic [2:0]    irq_level;
  logic [SW-1:0] irq_src;
  logic          irq_service_sel;
  logic          irq_accept;

  irq_level_arbiter #(.N_SRC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_event(src_event), .src_clear(src_clear),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .cpu_mask(cpu_mask), .cpu_ie(cpu_ie), .irq_valid(irq_valid),
    .irq_level(irq_level), .irq_src(irq_src), .irq_service_sel(irq_service_sel),
    .irq_accept(irq_accept)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // shadow model of requirement-level state
  int m_lvl [N];
  bit m_en  [N];
  bit m_ss  [N];
  bit m_pend[N];
  int m_mask = 7;
  bit m_ie = 1'b1;

  task automatic check_out(input string tag);
    int best = -1;
    int e_lvl, e_src, e_ss, e_acc, e_val;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && m_en[i] && m_lvl[i] != 7)
        if (best < 0 || m_lvl[i] < m_lvl[best]) best = i;
    e_val = (best >= 0);
    e_lvl = e_val ? m_lvl[best] : 7;
    e_src = e_val ? best : 0;
    e_ss  = e_val ? int'(m_ss[best]) : 0;
    e_acc = (e_val && m_ie && e_lvl < m_mask) ? 1 : 0;
    n_chk++;
    if (int'(irq_valid) != e_val || int'(irq_level) != e_lvl || int'(irq_src) != e_src ||
        int'(irq_service_sel) != e_ss || int'(irq_accept) != e_acc) begin
      n_fail++;
      $display("FAIL %s: got v=%0d lvl=%0d src=%0d ss=%0d acc=%0d expected v=%0d lvl=%0d src=%0d ss=%0d acc=%0d",
               tag, irq_valid, irq_level, irq_src, irq_service_sel, irq_accept,
               e_val, e_lvl, e_src, e_ss, e_acc);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic cfg(input int s, input bit en, input bit ss, input int lvl);
    cfg_wr_en = 1'b1; cfg_wr_addr = SW'(s); cfg_wr_data = {en, ss, 3'(lvl)};
    @(negedge clk);
    cfg_wr_en = 1'b0;
    m_en[s] = en; m_ss[s] = ss; m_lvl[s] = lvl;
  endtask

  task automatic strobe(input logic [N-1:0] ev, input logic [N-1:0] cl);
    src_event = ev; src_clear = cl;
    @(negedge clk);
    src_event = '0; src_clear = '0;
    for (int i = 0; i < N; i++) begin
      if (ev[i]) m_pend[i] = 1'b1;
      else if (cl[i]) m_pend[i] = 1'b0;
    end
  endtask

  task automatic cpu(input int mask, input bit ie);
    cpu_mask = 3'(mask); cpu_ie = ie; m_mask = mask; m_ie = ie;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check_out("R1 reset outputs");
    check_bit("R1 reset level7", irq_level == 3'd7, 1'b1);
  endtask

  task automatic t_eligibility();
    cfg(5, 1'b0, 1'b0, 3);
    strobe(N'(1) << 5, '0);
    settle();
    check_out("R2 pending but disabled");
    cfg(5, 1'b1, 1'b0, 7);
    settle();
    check_out("R2 level 7 disables");
    cfg(5, 1'b1, 1'b0, 3);
    check_bit("R12 write not yet visible", irq_valid, 1'b0);
    settle();
    check_out("R10 R2 enabled source competes");
    strobe('0, N'(1) << 5);
    settle();
    check_out("R11 idle after clear");
  endtask

  task automatic t_latency();
    cfg(8, 1'b1, 1'b0, 4);
    strobe(N'(1) << 8, '0);
    check_bit("R12 event not yet visible", irq_valid, 1'b0);
    settle();
    check_out("R12 event visible one edge later");
    strobe('0, N'(1) << 8);
    settle();
  endtask

  task automatic t_priority();
    cfg(2, 1'b1, 1'b0, 5);
    cfg(9, 1'b1, 1'b0, 1);
    cfg(12, 1'b1, 1'b0, 4);
    strobe((N'(1) << 2) | (N'(1) << 9) | (N'(1) << 12), '0);
    settle();
    check_out("R3 smallest level wins");
    check_bit("R3 src is 9", irq_src == 4'd9, 1'b1);
    strobe('0, N'(1) << 9);
    settle();
    check_out("R3 next smallest after clear");
  endtask

  task automatic t_tie();
    cfg(11, 1'b1, 1'b0, 2);
    cfg(3, 1'b1, 1'b0, 2);
    strobe((N'(1) << 3) | (N'(1) << 11), '0);
    settle();
    check_out("R4 tie goes to lower number");
    check_bit("R4 src is 3", irq_src == 4'd3, 1'b1);
    strobe('0, N'(1) << 3);
    settle();
    check_out("R4 remaining tie member");
    // level rewrite of a pending source moves the winner
    cfg(12, 1'b1, 1'b0, 0);
    settle();
    check_out("R10 rewrite of pending source");
    cfg(12, 1'b1, 1'b0, 4);
    settle();
  endtask

  task automatic t_accept();
    cpu(2, 1'b1);
    settle();
    check_out("R5 level equal to mask refused");
    check_bit("R5 accept low", irq_accept, 1'b0);
    cpu(3, 1'b1);
    settle();
    check_out("R5 level below mask accepted");
    cpu(7, 1'b0);
    settle();
    check_out("R6 ie low blocks accept");
    cpu(7, 1'b1);
    settle();
    check_out("R12 accept follows mask after one edge");
  endtask

  task automatic t_service();
    cfg(11, 1'b1, 1'b1, 2);
    settle();
    check_out("R7 service select shown");
    check_bit("R7 ss high", irq_service_sel, 1'b1);
  endtask

  task automatic t_hold();
    repeat (5) settle();
    check_out("R8 flag holds without clear");
    strobe('0, N'(1) << 11);
    settle();
    check_out("R8 clear drops flag");
  endtask

  task automatic t_same_cycle();
    cfg(6, 1'b1, 1'b0, 0);
    strobe(N'(1) << 6, N'(1) << 6);
    settle();
    check_out("R9 event beats clear");
    check_bit("R9 src is 6", irq_src == 4'd6, 1'b1);
    strobe('0, N'(1) << 6);
    settle();
  endtask

  task automatic t_idle();
    strobe('0, '1);
    settle();
    check_out("R11 nothing pending");
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_lvl[i] = 7; m_en[i] = 1'b0; m_ss[i] = 1'b0; m_pend[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    settle();
    t_reset();
    t_eligibility();
    t_latency();
    t_priority();
    t_tie();
    t_accept();
    t_service();
    t_hold();
    t_same_cycle();
    t_idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule